// File: doc/BRIEF.md
# DMA Burst Length Planner

This block turns one DMA buffer transfer into a sequence of host-bus bursts. A transmit or a receive channel hands over a buffer as a start byte address and a byte length. The planner then issues one burst at a time over a valid/ready handshake. Each burst carries a start address, a beat count, a burst kind (SINGLE, INCR or FIXED), a flag on the final burst of the buffer and the channel it belongs to. The bus width in bytes is a build-time parameter. The engine that moves the data consumes the bursts one by one.

The size of each burst comes from a shared set of bus-mode controls. A programmable burst length can be scaled by eight. The receive channel can take its length from a field of its own. A fixed-burst mode restricts sizes to 1, 4, 8 or 16 beats. An address-aligned mode keeps bursts from crossing a burst-sized address boundary. In fixed mode the aligned rule covers every burst. Otherwise it covers every burst after the first. The two request ports are served one buffer at a time, in round-robin order. The configuration is assumed stable while a buffer is in progress.

Top module: `dma_burst_planner`

## Requirements
- R1: A length field is legal only when it holds 1, 2, 4, 8, 16 or 32. An illegal field in use raises `cfg_err`, and that channel bursts as if the field held 1. The receive field counts only while `cfg_split_rx` is 1.
- R2: With `cfg_x8` = 1 the effective length E is the legal field value times eight (8 to 256 beats). Otherwise E equals the field value.
- R3: With `cfg_split_rx` = 1 a receive buffer takes E from `cfg_rx_pbl` and a transmit buffer from `cfg_pbl`. With it 0, both take E from `cfg_pbl`.
- R4: With `cfg_fixed` = 1 every burst has `bst_kind` = 2 (FIXED). Its beat count is the largest of 16, 8, 4 or 1 that does not exceed the smaller of the cap and the remaining beats. The cap is M = the largest of 16, 8, 4 or 1 not above E, reduced by the alignment rule.
- R5: With `cfg_fixed` = 0, M = E. Each burst carries min(cap, remaining beats) beats. `bst_kind` is 0 (SINGLE) for one beat and 1 (INCR) otherwise.
- R6: With `cfg_aligned` = 1 and `cfg_fixed` = 1, no burst, including the first, crosses a boundary of M bus words. The cap is M minus the start word index modulo M.
- R7: With `cfg_aligned` = 1 and `cfg_fixed` = 0, the first burst is capped only by M. Every later burst stops at the next M-word boundary.
- R8: A buffer needs ceil((start address mod bus bytes + length) / bus bytes) beats in total. The first burst address is the start address. Each later address is the previous address rounded down to a bus word plus the previous beats times bus bytes. `bst_last` is 1 on the final burst only, and `bst_rx` names the channel.
- R9: While `bst_valid` is 1 and `bst_ready` is 0, all burst outputs hold their values.
- R10: At most one request ready is 1 at a time, and none while a buffer is in progress. When both channels request, they alternate, starting with transmit after reset.
- R11: A buffer of length zero is accepted and produces no burst.
- R12: During and right after reset `bst_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pbl | input | 6 | Main burst length field |
| cfg_rx_pbl | input | 6 | Receive burst length field |
| cfg_x8 | input | 1 | Multiply burst length by eight |
| cfg_split_rx | input | 1 | Receive uses its own length field |
| cfg_fixed | input | 1 | Fixed-size burst mode |
| cfg_aligned | input | 1 | Address-aligned burst mode |
| cfg_err | output | 1 | Length field in use is illegal |
| tx_req_valid | input | 1 | Transmit buffer offered |
| tx_req_ready | output | 1 | Transmit buffer taken |
| tx_req_addr | input | ADDR_W | Transmit buffer start byte address |
| tx_req_len | input | LEN_W | Transmit buffer byte length |
| rx_req_valid | input | 1 | Receive buffer offered |
| rx_req_ready | output | 1 | Receive buffer taken |
| rx_req_addr | input | ADDR_W | Receive buffer start byte address |
| rx_req_len | input | LEN_W | Receive buffer byte length |
| bst_valid | output | 1 | Burst descriptor valid |
| bst_ready | input | 1 | Burst descriptor consumed |
| bst_addr | output | ADDR_W | Burst start byte address |
| bst_beats | output | 9 | Burst beat count |
| bst_kind | output | 2 | 0 SINGLE, 1 INCR, 2 FIXED |
| bst_last | output | 1 | Final burst of the buffer |
| bst_rx | output | 1 | Burst belongs to the receive channel |

## Verification
`tx_req_ready`, `rx_req_ready` and `cfg_err` are combinational, so they are due in the same cycle as the inputs that drive them. The first burst of a buffer is valid in the cycle after the edge that takes the request. Each later burst is presented in the cycle after the edge that completes the previous handshake. The bench therefore drives inputs on the falling edge and samples every output one nanosecond later. At that point each registered result reflects exactly one rising edge since the stimulus. A burst is compared against the bench's expected list only in a cycle where the bench is also asserting `bst_ready`.

// File: rtl/dma_bp_pkg.sv
// Package: shared constants, the burst-kind encoding and small helpers
// used by the burst planner. Assumes burst lengths are powers of two.
package dma_bp_pkg;

    localparam int unsigned MAX_PBL = 32;
    localparam int unsigned PBL_MUL = 8;
    localparam int unsigned BEAT_W  = $clog2(MAX_PBL * PBL_MUL) + 1;

    typedef enum logic [1:0] {
        BK_SINGLE = 2'd0,
        BK_INCR   = 2'd1,
        BK_FIXED  = 2'd2
    } burst_kind_e;

    // True when a raw length field holds a permitted power of two.
    function automatic logic pbl_legal(input logic [5:0] v);
        return (v == 6'd1) || (v == 6'd2) || (v == 6'd4) ||
               (v == 6'd8) || (v == 6'd16) || (v == 6'd32);
    endfunction

    // Largest fixed burst size (16, 8, 4 or 1) not above n; 1 for n < 4.
    function automatic logic [BEAT_W-1:0] fixed_floor(input logic [BEAT_W-1:0] n);
        if (n >= BEAT_W'(16))     return BEAT_W'(16);
        else if (n >= BEAT_W'(8)) return BEAT_W'(8);
        else if (n >= BEAT_W'(4)) return BEAT_W'(4);
        else                      return BEAT_W'(1);
    endfunction

endpackage

// File: rtl/dma_bp_pbl_resolve.sv
// Module: checks one raw burst length field and produces its effective
// beat count. An illegal field is reported and replaced by 1 beat.
// Assumes BEAT_W is wide enough for 32 x 8.
module dma_bp_pbl_resolve
    import dma_bp_pkg::*;
(
    input  logic [5:0]        raw,
    input  logic              x8,
    output logic [BEAT_W-1:0] eff,
    output logic              bad
);
    logic [BEAT_W-1:0] base;

    // Validate the field, clamp and apply the optional times-eight scale.
    always_comb begin
        bad  = !pbl_legal(raw);
        base = bad ? BEAT_W'(1) : BEAT_W'(raw);
        eff  = x8 ? (base << 3) : base;
    end
endmodule

// File: rtl/dma_bp_rr_arb.sv
// Module: two-way round-robin grant for the transmit (bit 0) and receive
// (bit 1) request ports. Grants only while enabled; after reset the
// transmit side wins the first tie. Assumes a grant is always taken.
module dma_bp_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       en,
    output logic [1:0] gnt
);
    logic last_rx;

    // Pick the requester; on a tie, the one not served last.
    always_comb begin
        if (!en)         gnt = 2'b00;
        else if (&req)   gnt = last_rx ? 2'b01 : 2'b10;
        else             gnt = req;
    end

    // Remember which side was served most recently.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_rx <= 1'b1;
        else if (|gnt)   last_rx <= gnt[1];
    end
endmodule

// File: rtl/dma_bp_sizer.sv
// Module: combinational sizing of the current burst from the effective
// length, the current word index, the remaining word count and the mode
// bits. Assumes eff is a power of two in 1..256 and NEED_W > BEAT_W.
module dma_bp_sizer
    import dma_bp_pkg::*;
#(
    parameter int unsigned NEED_W = 17
) (
    input  logic [BEAT_W-1:0] eff,
    input  logic [BEAT_W-1:0] widx_lo,
    input  logic [NEED_W-1:0] need,
    input  logic              first,
    input  logic              fixed_mode,
    input  logic              aligned_mode,
    output logic [BEAT_W-1:0] lim,
    output logic [BEAT_W-1:0] beats,
    output burst_kind_e       kind,
    output logic              last
);
    logic [BEAT_W-1:0] span;
    logic [BEAT_W-1:0] cap;
    logic [BEAT_W-1:0] n;

    // Burst ceiling, alignment cut, remaining-data cut and size snapping.
    always_comb begin
        lim  = fixed_mode ? fixed_floor(eff) : eff;
        span = lim - (widx_lo & (lim - BEAT_W'(1)));
        cap  = (aligned_mode && (fixed_mode || !first)) ? span : lim;
        n    = (NEED_W'(cap) <= need) ? cap : BEAT_W'(need);
        beats = fixed_mode ? fixed_floor(n) : n;
        if (fixed_mode)               kind = BK_FIXED;
        else if (beats == BEAT_W'(1)) kind = BK_SINGLE;
        else                          kind = BK_INCR;
        last = (NEED_W'(beats) == need);
    end
endmodule

// File: rtl/dma_burst_planner.sv
// Module: top of the burst planner. Takes one buffer at a time from the
// transmit or receive port, then issues its bursts over a valid/ready
// handshake. Assumes the cfg_* inputs stay stable while a buffer is in
// progress and that ADDR_W >= log2(BUS_BYTES) + 9.
module dma_burst_planner
    import dma_bp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        cfg_pbl,
    input  logic [5:0]        cfg_rx_pbl,
    input  logic              cfg_x8,
    input  logic              cfg_split_rx,
    input  logic              cfg_fixed,
    input  logic              cfg_aligned,
    output logic              cfg_err,
    input  logic              tx_req_valid,
    output logic              tx_req_ready,
    input  logic [ADDR_W-1:0] tx_req_addr,
    input  logic [LEN_W-1:0]  tx_req_len,
    input  logic              rx_req_valid,
    output logic              rx_req_ready,
    input  logic [ADDR_W-1:0] rx_req_addr,
    input  logic [LEN_W-1:0]  rx_req_len,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [8:0]        bst_beats,
    output logic [1:0]        bst_kind,
    output logic              bst_last,
    output logic              bst_rx
);
    localparam int unsigned OFF_W  = $clog2(BUS_BYTES);
    localparam int unsigned NEED_W = LEN_W + 1;
    localparam int unsigned N_CH   = 2;

    // Length field resolution, one resolver per channel field.
    logic [5:0]        raw_pbl [N_CH];
    logic [BEAT_W-1:0] eff_pbl [N_CH];
    logic [N_CH-1:0]   pbl_bad;

    assign raw_pbl[0] = cfg_pbl;
    assign raw_pbl[1] = cfg_rx_pbl;

    for (genvar c = 0; c < N_CH; c++) begin : g_pbl
        dma_bp_pbl_resolve u_res (
            .raw (raw_pbl[c]),
            .x8  (cfg_x8),
            .eff (eff_pbl[c]),
            .bad (pbl_bad[c])
        );
    end

    assign cfg_err = pbl_bad[0] | (cfg_split_rx & pbl_bad[1]);

    // Buffer state.
    logic              busy;
    logic              cur_rx;
    logic              first_burst;
    logic [ADDR_W-1:0] cur_addr;
    logic [NEED_W-1:0] cur_need;

    // Request arbitration.
    logic [1:0] gnt;

    dma_bp_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({rx_req_valid, tx_req_valid}),
        .en    (!busy),
        .gnt   (gnt)
    );

    assign tx_req_ready = gnt[0];
    assign rx_req_ready = gnt[1];

    logic [ADDR_W-1:0] sel_addr;
    logic [LEN_W-1:0]  sel_len;
    logic [NEED_W-1:0] need_init;

    // Choose the granted buffer and convert its byte span to bus words.
    always_comb begin
        sel_addr  = gnt[1] ? rx_req_addr : tx_req_addr;
        sel_len   = gnt[1] ? rx_req_len  : tx_req_len;
        need_init = (NEED_W'(sel_len) + NEED_W'(sel_addr[OFF_W-1:0])
                     + NEED_W'(BUS_BYTES - 1)) >> OFF_W;
    end

    // Burst sizing for the buffer in progress.
    logic [BEAT_W-1:0] eff_cur;
    logic [BEAT_W-1:0] burst_lim;
    logic [BEAT_W-1:0] beats;
    burst_kind_e       kind;
    logic              is_last;

    assign eff_cur = (cur_rx && cfg_split_rx) ? eff_pbl[1] : eff_pbl[0];

    dma_bp_sizer #(.NEED_W(NEED_W)) u_size (
        .eff          (eff_cur),
        .widx_lo      (cur_addr[OFF_W +: BEAT_W]),
        .need         (cur_need),
        .first        (first_burst),
        .fixed_mode   (cfg_fixed),
        .aligned_mode (cfg_aligned),
        .lim          (burst_lim),
        .beats        (beats),
        .kind         (kind),
        .last         (is_last)
    );

    logic [ADDR_W-1:0] next_addr;

    // Next burst starts at the word-aligned address past this one.
    always_comb begin
        next_addr = {cur_addr[ADDR_W-1:OFF_W], OFF_W'(0)}
                    + (ADDR_W'(beats) << OFF_W);
    end

    // Take a buffer when idle, then step through its bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            cur_rx      <= 1'b0;
            first_burst <= 1'b0;
            cur_addr    <= '0;
            cur_need    <= '0;
        end else if (|gnt) begin
            busy        <= (need_init != '0);
            cur_rx      <= gnt[1];
            first_burst <= 1'b1;
            cur_addr    <= sel_addr;
            cur_need    <= need_init;
        end else if (busy && bst_ready) begin
            cur_need    <= cur_need - NEED_W'(beats);
            cur_addr    <= next_addr;
            first_burst <= 1'b0;
            if (is_last) busy <= 1'b0;
        end
    end

    assign bst_valid = busy;
    assign bst_addr  = cur_addr;
    assign bst_beats = beats;
    assign bst_kind  = kind;
    assign bst_last  = is_last;
    assign bst_rx    = cur_rx;

endmodule

// File: rtl/dma_burst_planner_chk.sv
// Checker: protocol and sizing properties of the burst planner, bound
// into every instance of the top module.
module dma_burst_planner_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned BEAT_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_req_ready,
    input logic              rx_req_ready,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [8:0]        bst_beats,
    input logic [1:0]        bst_kind,
    input logic              bst_last,
    input logic              cfg_fixed,
    input logic              cfg_aligned,
    input logic              first_burst,
    input logic [BEAT_W-1:0] burst_lim
);
    logic [BEAT_W:0] pos_in;
    logic [BEAT_W:0] end_pos;

    // Word position inside the current boundary window and burst end.
    always_comb begin
        pos_in  = {1'b0, bst_addr[OFF_W +: BEAT_W] & (burst_lim - BEAT_W'(1))};
        end_pos = pos_in + (BEAT_W+1)'(bst_beats);
    end

    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_req_ready, rx_req_ready}));

    a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> !(tx_req_ready || rx_req_ready));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid && !bst_ready |=> bst_valid && $stable(bst_addr) &&
        $stable(bst_beats) && $stable(bst_kind) && $stable(bst_last));

    a_r4_fixed_size: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid && cfg_fixed |-> bst_kind == 2'd2 &&
        (bst_beats == 9'd1 || bst_beats == 9'd4 ||
         bst_beats == 9'd8 || bst_beats == 9'd16));

    a_r5_kind: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid && !cfg_fixed |->
        bst_kind == ((bst_beats == 9'd1) ? 2'd0 : 2'd1));

    a_r6_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid && cfg_aligned && (cfg_fixed || !first_burst) |->
        end_pos <= {1'b0, burst_lim});

    a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> bst_beats != 9'd0);

endmodule

bind dma_burst_planner dma_burst_planner_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .BEAT_W (dma_bp_pkg::BEAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_req_ready (tx_req_ready),
    .rx_req_ready (rx_req_ready),
    .bst_valid    (bst_valid),
    .bst_ready    (bst_ready),
    .bst_addr     (bst_addr),
    .bst_beats    (bst_beats),
    .bst_kind     (bst_kind),
    .bst_last     (bst_last),
    .cfg_fixed    (cfg_fixed),
    .cfg_aligned  (cfg_aligned),
    .first_burst  (first_burst),
    .burst_lim    (burst_lim)
);

// File: tb/tb_dma_burst_planner.sv
`timescale 1ns/1ps
module tb_dma_burst_planner;
    localparam int BB     = 8;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] cfg_pbl = 6'd1, cfg_rx_pbl = 6'd1;
    logic cfg_x8 = 0, cfg_split_rx = 0, cfg_fixed = 0, cfg_aligned = 0;
    logic cfg_err;
    logic tx_req_valid = 0, rx_req_valid = 0;
    logic tx_req_ready, rx_req_ready;
    logic [ADDR_W-1:0] tx_req_addr = '0, rx_req_addr = '0;
    logic [LEN_W-1:0]  tx_req_len = '0, rx_req_len = '0;
    logic bst_valid, bst_ready = 0;
    logic [ADDR_W-1:0] bst_addr;
    logic [8:0] bst_beats;
    logic [1:0] bst_kind;
    logic bst_last, bst_rx;

    always #2.5 clk = ~clk;

    dma_burst_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BB)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pbl(cfg_pbl), .cfg_rx_pbl(cfg_rx_pbl), .cfg_x8(cfg_x8),
        .cfg_split_rx(cfg_split_rx), .cfg_fixed(cfg_fixed),
        .cfg_aligned(cfg_aligned), .cfg_err(cfg_err),
        .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
        .tx_req_addr(tx_req_addr), .tx_req_len(tx_req_len),
        .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready),
        .rx_req_addr(rx_req_addr), .rx_req_len(rx_req_len),
        .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_addr(bst_addr),
        .bst_beats(bst_beats), .bst_kind(bst_kind), .bst_last(bst_last),
        .bst_rx(bst_rx)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    longint e_addr [1024];
    int     e_beats[1024];
    int     e_kind [1024];
    int     e_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal(input int v);
        return v == 1 || v == 2 || v == 4 || v == 8 || v == 16 || v == 32;
    endfunction

    function automatic int eff_of(input int raw, input bit x8);
        int p;
        p = legal(raw) ? raw : 1;
        return x8 ? p * 8 : p;
    endfunction

    function automatic int ffloor(input int n);
        int sizes[4] = '{16, 8, 4, 1};
        foreach (sizes[k]) if (sizes[k] <= n) return sizes[k];
        return 1;
    endfunction

    // Expected burst list from the requirements.
    task automatic build_exp(input bit rx, input longint addr, input int len);
        int e, m, need, cap, n, b;
        longint a, w;
        bit first;
        e = (rx && cfg_split_rx) ? eff_of(int'(cfg_rx_pbl), cfg_x8)
                                 : eff_of(int'(cfg_pbl), cfg_x8);
        m = cfg_fixed ? ffloor(e) : e;
        need = int'((addr % BB + len + BB - 1) / BB);
        a = addr;
        first = 1;
        e_cnt = 0;
        while (need > 0) begin
            w = a / BB;
            cap = m;
            if (cfg_aligned && (cfg_fixed || !first)) cap = m - int'(w % m);
            n = (cap < need) ? cap : need;
            b = cfg_fixed ? ffloor(n) : n;
            e_addr[e_cnt]  = a;
            e_beats[e_cnt] = b;
            e_kind[e_cnt]  = cfg_fixed ? 2 : ((b == 1) ? 0 : 1);
            e_cnt++;
            need -= b;
            a = w * BB + longint'(b) * BB;
            first = 0;
        end
    endtask

    task automatic set_cfg(input int pbl, input int rpbl, input bit x8,
                           input bit sep, input bit fx, input bit al);
        @(negedge clk);
        cfg_pbl = 6'(pbl); cfg_rx_pbl = 6'(rpbl); cfg_x8 = x8;
        cfg_split_rx = sep; cfg_fixed = fx; cfg_aligned = al;
    endtask

    // Offer one buffer and check every burst it yields.
    task automatic do_buffer(input bit rx, input longint addr, input int len,
                             input string tag);
        bit exp_err, held;
        longint s_addr;
        int s_beats, s_kind, i;
        build_exp(rx, addr, len);
        @(negedge clk);
        if (rx) begin
            rx_req_valid = 1; rx_req_addr = ADDR_W'(addr); rx_req_len = LEN_W'(len);
        end else begin
            tx_req_valid = 1; tx_req_addr = ADDR_W'(addr); tx_req_len = LEN_W'(len);
        end
        #1;
        exp_err = !legal(int'(cfg_pbl)) || (cfg_split_rx && !legal(int'(cfg_rx_pbl)));
        chk(cfg_err == exp_err, "R1", "cfg_err", cfg_err, exp_err);
        chk((rx ? rx_req_ready : tx_req_ready) == 1'b1, "R10", "idle ready",
            rx ? rx_req_ready : tx_req_ready, 1);
        @(posedge clk);
        #1;
        tx_req_valid = 0; rx_req_valid = 0;
        if (e_cnt == 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1;
                chk(!bst_valid, "R11", "valid on empty buffer", bst_valid, 0);
            end
            return;
        end
        i = 0;
        held = 0;
        while (i < e_cnt) begin
            @(negedge clk);
            bst_ready = ($urandom % 4) != 0;
            #1;
            chk(bst_valid, {tag, "/R8"}, "valid during buffer", bst_valid, 1);
            chk(!tx_req_ready && !rx_req_ready, "R10", "ready while busy",
                tx_req_ready | rx_req_ready, 0);
            if (held)
                chk(bst_addr == ADDR_W'(s_addr) && bst_beats == 9'(s_beats) &&
                    bst_kind == 2'(s_kind), "R9", "held addr",
                    bst_addr, s_addr);
            if (bst_ready) begin
                chk(bst_addr == ADDR_W'(e_addr[i]), {tag, "/R8"}, "addr",
                    bst_addr, e_addr[i]);
                chk(int'(bst_beats) == e_beats[i], tag, "beats",
                    bst_beats, e_beats[i]);
                chk(int'(bst_kind) == e_kind[i], tag, "kind",
                    bst_kind, e_kind[i]);
                chk(bst_last == (i == e_cnt - 1), "R8", "last",
                    bst_last, i == e_cnt - 1);
                chk(bst_rx == rx, "R8", "channel", bst_rx, rx);
                i++;
                held = 0;
            end else begin
                held = 1;
                s_addr = bst_addr; s_beats = bst_beats; s_kind = bst_kind;
            end
        end
        @(negedge clk);
        bst_ready = 0;
        #1;
        chk(!bst_valid, "R8", "valid after last", bst_valid, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pv[6] = '{1, 2, 4, 8, 16, 32};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(!bst_valid, "R12", "valid in reset", bst_valid, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!bst_valid && !tx_req_ready && !rx_req_ready, "R12", "after reset",
            bst_valid, 0);

        // Both request with zero length: transmit first, then receive.
        @(negedge clk);
        tx_req_valid = 1; rx_req_valid = 1; tx_req_len = 0; rx_req_len = 0;
        #1;
        chk(tx_req_ready && !rx_req_ready, "R10", "first tie to tx",
            {rx_req_ready, tx_req_ready}, 1);
        @(negedge clk); #1;
        chk(rx_req_ready && !tx_req_ready, "R10", "second tie to rx",
            {rx_req_ready, tx_req_ready}, 2);
        chk(!bst_valid, "R11", "no burst for zero length", bst_valid, 0);
        @(negedge clk);
        tx_req_valid = 0; rx_req_valid = 0;

        // Directed corner cases.
        set_cfg(32, 1, 1, 0, 0, 1);
        do_buffer(0, 64'h1003, 5000, "R2/R7");
        set_cfg(16, 1, 0, 0, 1, 1);
        do_buffer(0, 64'h2018, 400, "R4/R6");
        set_cfg(3, 1, 0, 0, 0, 0);
        do_buffer(1, 64'h300, 40, "R1/R5");
        set_cfg(4, 16, 0, 1, 0, 0);
        do_buffer(1, 64'h4000, 300, "R3");
        do_buffer(0, 64'h4000, 300, "R3");
        set_cfg(4, 5, 0, 0, 0, 0);
        do_buffer(1, 64'h500, 100, "R1/R3");
        set_cfg(2, 1, 0, 0, 1, 0);
        do_buffer(0, 64'h605, 30, "R4");
        set_cfg(8, 1, 0, 0, 0, 1);
        do_buffer(1, 64'h700, 0, "R11");

        // Constrained random buffers.
        for (int t = 0; t < 60; t++) begin
            int p, rp;
            bit fx;
            p  = ($urandom % 10 == 0) ? int'($urandom % 64) : pv[$urandom % 6];
            rp = ($urandom % 10 == 0) ? int'($urandom % 64) : pv[$urandom % 6];
            fx = $urandom % 2;
            set_cfg(p, rp, $urandom % 2, $urandom % 2, fx, $urandom % 2);
            do_buffer($urandom % 2, longint'($urandom & 32'h0FFF_FFFF),
                      int'($urandom % 1500), fx ? "R4" : "R5");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule